// File: doc/BRIEF.md
# Configurable UART Character Receiver

This block turns an asynchronous serial line into parallel words. The line rests high. A character opens with one low start bit. Then come a run-time selectable number of data bits, sent least significant bit first, and an optional parity bit. It closes with one or two high stop bits. The receiver works from a free-running oversample tick, 16 ticks per bit by default, supplied by an external baud generator. It samples every bit near its centre.

The host sets the data length, the parity mode and the stop-bit count through static configuration inputs. The receiver captures them when it detects a start bit. For each character the block produces a one-cycle valid pulse together with the assembled word and two error flags: a parity mismatch and a low stop bit (a framing error). The word and the flags stay on the outputs until the next character completes.

Bit timing restarts from every start edge, so small rate differences between sender and receiver do not build up across characters. The receiver goes back to idle at the centre of the final stop bit, which means a start bit that directly follows the stop bit is accepted without any idle gap.

Top module: `uart_char_rx`

## Requirements
- R1: After reset, word_valid, word_data, word_parity_err and word_frame_err are all 0. While rx_line stays high the receiver produces no word.
- R2: A low level seen on a tick starts a frame. The low level is checked again half a bit (8 ticks) later. If the line is high by then, the receiver returns to idle and produces no word, so a pulse shorter than half a bit is ignored.
- R3: The data length is 5 + cfg_len_code: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Bits arrive least significant first and are sampled one bit period apart, starting one bit after the start-bit check. The bits of word_data above the configured length are 0.
- R4: When cfg_parity_en is 1, one parity bit follows the data. With cfg_parity_odd = 0 the data bits plus the parity bit must hold an even number of ones. With cfg_parity_odd = 1 they must hold an odd number. A mismatch sets word_parity_err. When cfg_parity_en is 0 there is no parity bit and word_parity_err is 0.
- R5: cfg_two_stop = 0 selects one stop bit and 1 selects two. word_frame_err is 1 when any checked stop bit is sampled low. The word is still delivered in that case.
- R6: word_valid is high for exactly one clock per received character. word_data and both flags are valid in that cycle and keep their values until the next character.
- R7: A start bit that begins right at the end of the last stop bit is received correctly, with no idle time between characters.
- R8: Bit timing restarts on every start bit. Back-to-back 8-bit frames whose bit period is about 3% shorter or longer than nominal are all received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_tick | input | 1 | One-clock pulse at 16 times the bit rate |
| rx_line | input | 1 | Serial input line, idles high |
| cfg_len_code | input | 2 | Data length code, length = 5 + code |
| cfg_parity_en | input | 1 | Enables the parity bit |
| cfg_parity_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| word_valid | output | 1 | One-cycle pulse when a character is complete |
| word_data | output | 8 | Received data, upper bits zero for short formats |
| word_parity_err | output | 1 | Parity mismatch on the delivered word |
| word_frame_err | output | 1 | A stop bit was sampled low on the delivered word |

## Verification
The hardest situation to reach is a run of characters with no idle gap whose bit period is off nominal. In that case the receiver's return to idle at mid-stop must land before the next start edge. The bench drives frames back to back at 62- and 66-clock bit periods against a 64-clock nominal bit. Without realignment on each start bit, the error would add up to more than half a bit within two characters. Short low glitches and stop bits held low for only part of the bit period are also shaped on the line directly. These put the start-confirm and stop-sample points right against a line that changes between them.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PARITY,
      ST_STOP
   } rx_state_e;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
   parameter int STAGES = 2
)(
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 0) begin : g_bad
         $error("uart_rx_sync: STAGES must be non-negative");
      end

      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] stage_q;
         for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) stage_q[0] <= 1'b1;
                  else        stage_q[0] <= d;
               end
            end else begin : g_next
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) stage_q[i] <= 1'b1;
                  else        stage_q[i] <= stage_q[i-1];
               end
            end
         end
         assign q = stage_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/uart_rx_bit_timer.sv
module uart_rx_bit_timer #(
   parameter int OVERSAMPLE = 16
)(
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic clear,
   output logic at_mid,
   output logic at_end
);

   localparam int CNT_W = (OVERSAMPLE > 2) ? $clog2(OVERSAMPLE) : 1;
   localparam int HALF  = OVERSAMPLE / 2;

   generate
      if (OVERSAMPLE < 4 || (OVERSAMPLE % 2) != 0) begin : g_bad
         $error("uart_rx_bit_timer: OVERSAMPLE must be even and at least 4");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;

   assign at_mid = tick && (cnt == CNT_W'(HALF - 1));
   assign at_end = tick && (cnt == CNT_W'(OVERSAMPLE - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (clear)  cnt <= '0;
      else if (at_end) cnt <= '0;
      else if (tick)   cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/uart_rx_assembler.sv
module uart_rx_assembler #(
   parameter int DATA_W = 8
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clear,
   input  logic                      load,
   input  logic [IDX_W-1:0]          bit_idx,
   input  logic                      bit_in,
   output logic [DATA_W-1:0]         data,
   output logic                      ones_odd
);

   localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

   generate
      if (DATA_W < 1) begin : g_bad
         $error("uart_rx_assembler: DATA_W must be at least 1");
      end
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               data[i] <= 1'b0;
            else if (clear)
               data[i] <= 1'b0;
            else if (load && (bit_idx == IDX_W'(i)))
               data[i] <= bit_in;
         end
      end
   endgenerate

   assign ones_odd = ^data;

endmodule

// File: rtl/uart_char_rx.sv
module uart_char_rx
   import uart_rx_pkg::*;
#(
   parameter int OVERSAMPLE    = 16,
   parameter int MIN_DATA_BITS = 5,
   parameter int LEN_CODE_W    = 2,
   parameter int SYNC_STAGES   = 2
)(
   input  logic                                      clk,
   input  logic                                      rst_n,
   input  logic                                      sample_tick,
   input  logic                                      rx_line,
   input  logic [LEN_CODE_W-1:0]                     cfg_len_code,
   input  logic                                      cfg_parity_en,
   input  logic                                      cfg_parity_odd,
   input  logic                                      cfg_two_stop,
   output logic                                      word_valid,
   output logic [MIN_DATA_BITS+(2**LEN_CODE_W)-2:0]  word_data,
   output logic                                      word_parity_err,
   output logic                                      word_frame_err
);

   localparam int DATA_W = MIN_DATA_BITS + (2**LEN_CODE_W) - 1;
   localparam int IDX_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1;

   generate
      if (MIN_DATA_BITS < 1 || LEN_CODE_W < 1) begin : g_bad
         $error("uart_char_rx: MIN_DATA_BITS and LEN_CODE_W must be positive");
      end
   endgenerate

   rx_state_e         state;
   logic              line_s;
   logic              at_mid, at_end;
   logic              tmr_clear, start_ok;
   logic              asm_load;
   logic [DATA_W-1:0] asm_data;
   logic              asm_ones;
   logic [IDX_W-1:0]  bit_idx, last_idx;
   logic              lat_par_en, lat_par_odd, lat_two_stop;
   logic              second_stop;
   logic              perr_q, ferr_q;
   logic              stop_bad;

   uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (rx_line),
      .q     (line_s)
   );

   uart_rx_bit_timer #(.OVERSAMPLE(OVERSAMPLE)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (sample_tick),
      .clear  (tmr_clear),
      .at_mid (at_mid),
      .at_end (at_end)
   );

   uart_rx_assembler #(.DATA_W(DATA_W)) u_asm (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (start_ok),
      .load     (asm_load),
      .bit_idx  (bit_idx),
      .bit_in   (line_s),
      .data     (asm_data),
      .ones_odd (asm_ones)
   );

   assign start_ok  = (state == ST_START) && at_mid && !line_s;
   assign tmr_clear = (state == ST_IDLE) || start_ok;
   assign asm_load  = (state == ST_DATA) && at_end;
   assign stop_bad  = !line_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state           <= ST_IDLE;
         bit_idx         <= '0;
         last_idx        <= '0;
         lat_par_en      <= 1'b0;
         lat_par_odd     <= 1'b0;
         lat_two_stop    <= 1'b0;
         second_stop     <= 1'b0;
         perr_q          <= 1'b0;
         ferr_q          <= 1'b0;
         word_valid      <= 1'b0;
         word_data       <= '0;
         word_parity_err <= 1'b0;
         word_frame_err  <= 1'b0;
      end else begin
         word_valid <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (sample_tick && !line_s) begin
                  state        <= ST_START;
                  last_idx     <= IDX_W'(MIN_DATA_BITS - 1) + IDX_W'(cfg_len_code);
                  lat_par_en   <= cfg_parity_en;
                  lat_par_odd  <= cfg_parity_odd;
                  lat_two_stop <= cfg_two_stop;
               end
            end
            ST_START: begin
               if (at_mid) begin
                  if (line_s) begin
                     state <= ST_IDLE;
                  end else begin
                     state       <= ST_DATA;
                     bit_idx     <= '0;
                     second_stop <= 1'b0;
                     perr_q      <= 1'b0;
                     ferr_q      <= 1'b0;
                  end
               end
            end
            ST_DATA: begin
               if (at_end) begin
                  if (bit_idx == last_idx)
                     state <= lat_par_en ? ST_PARITY : ST_STOP;
                  else
                     bit_idx <= bit_idx + 1'b1;
               end
            end
            ST_PARITY: begin
               if (at_end) begin
                  perr_q <= line_s != (asm_ones ^ lat_par_odd);
                  state  <= ST_STOP;
               end
            end
            ST_STOP: begin
               if (at_end) begin
                  if (lat_two_stop && !second_stop) begin
                     second_stop <= 1'b1;
                     ferr_q      <= stop_bad;
                  end else begin
                     word_valid      <= 1'b1;
                     word_data       <= asm_data;
                     word_parity_err <= perr_q;
                     word_frame_err  <= ferr_q | stop_bad;
                     state           <= ST_IDLE;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R6: the completion strobe never lasts two cycles
   a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |=> !word_valid);

   // R3: bits above the latched length are clear on delivery
   a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |-> ((int'(word_data) >> (int'(last_idx) + 1)) == 0));

   // R2: a start bit that is high again at its centre is dropped
   a_r2_glitch_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_START && at_mid && line_s) |=> (state == ST_IDLE));

   // R2: a confirmed start leaves the assembler empty
   a_r2_confirm_clears: assert property (@(posedge clk) disable iff (!rst_n)
      start_ok |=> (asm_data == '0));

   // R1: a high line keeps the receiver idle
   a_r1_stay_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && line_s) |=> (state == ST_IDLE));

   // R4: no parity error without a parity bit
   a_r4_no_parity_err: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid && !lat_par_en) |-> !word_parity_err);

endmodule

// File: tb/uart_char_rx_tb.sv
module uart_char_rx_tb;

   localparam int TICK_DIV = 4;
   localparam int NOM_BIT  = 16 * TICK_DIV;
   localparam int NVEC     = 12;

   // fields: data[15:8] len_code[7:6] par_en[5] par_odd[4] two_stop[3]
   //         bad_par[2] bad_stop1[1] bad_stop2[0]
   localparam logic [15:0] VEC [NVEC] = '{
      {8'hA5, 2'b11, 6'b000000},
      {8'h57, 2'b10, 6'b000000},
      {8'hFF, 2'b00, 6'b000000},
      {8'h3C, 2'b11, 6'b100000},
      {8'h3D, 2'b11, 6'b110000},
      {8'h81, 2'b11, 6'b100100},
      {8'h6E, 2'b01, 6'b110100},
      {8'hC3, 2'b11, 6'b001000},
      {8'h5A, 2'b11, 6'b000010},
      {8'h0F, 2'b11, 6'b101001},
      {8'h33, 2'b11, 6'b001010},
      {8'h00, 2'b10, 6'b110000}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sample_tick = 1'b0;
   logic       rx_line = 1'b1;
   logic [1:0] cfg_len_code = 2'b11;
   logic       cfg_parity_en = 1'b0;
   logic       cfg_parity_odd = 1'b0;
   logic       cfg_two_stop = 1'b0;
   logic       word_valid;
   logic [7:0] word_data;
   logic       word_parity_err;
   logic       word_frame_err;

   int   checks = 0;
   int   fails = 0;
   bit   done = 1'b0;
   int   vcount = 0;
   logic [7:0] log_data [64];
   logic       log_perr [64];
   logic       log_ferr [64];

   uart_char_rx u_dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .sample_tick     (sample_tick),
      .rx_line         (rx_line),
      .cfg_len_code    (cfg_len_code),
      .cfg_parity_en   (cfg_parity_en),
      .cfg_parity_odd  (cfg_parity_odd),
      .cfg_two_stop    (cfg_two_stop),
      .word_valid      (word_valid),
      .word_data       (word_data),
      .word_parity_err (word_parity_err),
      .word_frame_err  (word_frame_err)
   );

   always #10 clk = ~clk;

   initial begin
      int n = 0;
      forever begin
         @(negedge clk);
         sample_tick = (n == TICK_DIV - 1);
         n = (n == TICK_DIV - 1) ? 0 : n + 1;
      end
   end

   always @(negedge clk) begin
      if (word_valid) begin
         log_data[vcount % 64] = word_data;
         log_perr[vcount % 64] = word_parity_err;
         log_ferr[vcount % 64] = word_frame_err;
         vcount++;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic hold_line(input logic val, input int clks);
      rx_line = val;
      repeat (clks) @(negedge clk);
   endtask

   task automatic send_stop(input logic bad, input int bitc);
      if (bad) begin
         hold_line(1'b0, 44);
         hold_line(1'b1, bitc - 44);
      end else begin
         hold_line(1'b1, bitc);
      end
   endtask

   function automatic logic [7:0] len_mask(input logic [1:0] lc);
      return 8'((1 << (5 + int'(lc))) - 1);
   endfunction

   task automatic send_frame(input logic [15:0] v, input int bitc);
      logic [7:0] d;
      logic [7:0] md;
      int nb;
      d  = v[15:8];
      nb = 5 + int'(v[7:6]);
      md = d & len_mask(v[7:6]);
      cfg_len_code   = v[7:6];
      cfg_parity_en  = v[5];
      cfg_parity_odd = v[4];
      cfg_two_stop   = v[3];
      hold_line(1'b0, bitc);
      for (int i = 0; i < nb; i++) hold_line(d[i], bitc);
      if (v[5]) hold_line((^md) ^ v[4] ^ v[2], bitc);
      send_stop(v[1], bitc);
      if (v[3]) send_stop(v[0], bitc);
   endtask

   initial begin
      int base;
      logic [15:0] v;
      logic [7:0] held;

      repeat (5) @(negedge clk);
      // R1: reset values
      check("R1 reset valid", 32'(word_valid), 32'd0);
      check("R1 reset data", 32'(word_data), 32'd0);
      check("R1 reset flags", {30'd0, word_parity_err, word_frame_err}, 32'd0);
      rst_n = 1'b1;
      hold_line(1'b1, 3 * NOM_BIT);
      check("R1 idle line gives no word", vcount, 0);

      // table of formats, parity and stop cases (R3 R4 R5)
      for (int k = 0; k < NVEC; k++) begin
         v = VEC[k];
         base = vcount;
         send_frame(v, NOM_BIT);
         hold_line(1'b1, 2 * NOM_BIT);
         check("R6 one word per frame", vcount, base + 1);
         check("R3 data and upper zero", 32'(log_data[base % 64]),
               32'(v[15:8] & len_mask(v[7:6])));
         check("R4 parity flag", 32'(log_perr[base % 64]), 32'(v[5] & v[2]));
         check("R5 framing flag", 32'(log_ferr[base % 64]),
               32'(v[1] | (v[3] & v[0])));
      end

      // R6: outputs held after the pulse
      held = word_data;
      base = vcount;
      hold_line(1'b1, 5 * NOM_BIT);
      check("R6 data held", 32'(word_data), 32'(held));
      check("R6 no extra pulse", vcount, base);

      // R2: short low glitches are rejected
      base = vcount;
      hold_line(1'b0, 16);
      hold_line(1'b1, 12 * NOM_BIT);
      hold_line(1'b0, 20);
      hold_line(1'b1, 12 * NOM_BIT);
      check("R2 glitch rejected", vcount, base);
      send_frame({8'h96, 2'b11, 6'b000000}, NOM_BIT);
      hold_line(1'b1, 2 * NOM_BIT);
      check("R2 frame after glitch count", vcount, base + 1);
      check("R2 frame after glitch data", 32'(log_data[base % 64]), 32'h96);

      // R7: back-to-back frames, mixed formats, no idle gap
      base = vcount;
      send_frame({8'h12, 2'b11, 6'b100000}, NOM_BIT);
      send_frame({8'h1F, 2'b00, 6'b001000}, NOM_BIT);
      send_frame({8'hE7, 2'b11, 6'b110000}, NOM_BIT);
      hold_line(1'b1, 2 * NOM_BIT);
      check("R7 back-to-back count", vcount, base + 3);
      check("R7 word 0", 32'(log_data[base % 64]), 32'h12);
      check("R7 word 1", 32'(log_data[(base + 1) % 64]), 32'h1F);
      check("R7 word 2", 32'(log_data[(base + 2) % 64]), 32'hE7);
      check("R7 no errors", {30'd0, log_perr[(base + 2) % 64], log_ferr[(base + 2) % 64]}, 32'd0);

      // R8: fast and slow senders, back to back
      for (int s = 0; s < 2; s++) begin
         int bitc;
         bitc = (s == 0) ? NOM_BIT - 2 : NOM_BIT + 2;
         base = vcount;
         for (int f = 0; f < 4; f++)
            send_frame({8'(8'h3B + 8'(f * 37)), 2'b11, 6'b000000}, bitc);
         hold_line(1'b1, 2 * NOM_BIT);
         check("R8 drift frame count", vcount, base + 4);
         for (int f = 0; f < 4; f++) begin
            check("R8 drift data", 32'(log_data[(base + f) % 64]), 32'(8'(8'h3B + 8'(f * 37))));
            check("R8 drift framing", 32'(log_ferr[(base + f) % 64]), 32'd0);
         end
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

endmodule